// File: doc/BRIEF.md
# I2C Read-Back Target with High-Speed Mode Tracking

This block is the serial target side of a 16-bit converter's register pair. It oversamples the two-wire bus lines (SCL, SDA) with a fast system clock and finds start, repeated-start and stop conditions. It acknowledges one 7-bit address whose lowest bit comes from a board strap. When the access is a read, it returns a three-byte frame: the upper data byte, the lower data byte, and a status byte. The status byte says whether the data came from the temporary holding register or the active conversion register.

The block also spots the high-speed master code (first byte `00001xxx`). It never acknowledges that code, but it raises a mode flag that the pad filters use. That flag holds across repeated starts and drops at the next stop. The SDA output is an open-drain pull-down enable. Write-side register decoding, the pads and the converter itself lie outside this block.

Top module: `i2c_readback_target`

## Requirements
- R1: After reset, `sda_pull_o` and `hs_mode_o` are both 0.
- R2: An address byte whose upper seven bits equal `1001100` with the last of them replaced by `strap_a0_i` (bit pattern `100110`,`strap_a0_i`) is acknowledged by pulling SDA low in the ninth SCL high period. Any other address gets no acknowledge, and SDA stays released until the next start.
- R3: In a read (address bit 0 = 1), the block sends the upper data byte, then the lower data byte, MSB first, with one master acknowledge between them. The data word and the source bit are captured when the address is matched and stay fixed for the whole frame.
- R4: The third byte of a read is the control byte. Bit 0 = 1 means the data came from the temporary register (`src_temp_i` = 1), and bit 0 = 0 means the active register. Bits 7..1 are 0.
- R5: If the master acknowledges the control byte, the next byte is the upper data byte again, and the byte order repeats.
- R6: After a master not-acknowledge, the block keeps SDA released until a start or a stop.
- R7: A first byte matching `00001xxx` is not acknowledged and sets `hs_mode_o` to 1. The flag stays at 1 across repeated starts.
- R8: A stop condition (SDA rising while SCL is high) clears `hs_mode_o` and releases SDA.
- R9: A start or repeated start (SDA falling while SCL is high) at any point ends the current byte and returns the block to address reception with SDA released.
- R10: `sda_pull_o` changes only after a synchronised SCL falling edge or a start or stop condition. It never changes while SCL is high inside a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_a0_i | input | 1 | Strap that sets the lowest address bit |
| conv_data_i | input | 16 | Data word offered for read-back |
| src_temp_i | input | 1 | 1 when `conv_data_i` holds the temporary register |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| hs_mode_o | output | 1 | High-speed mode flag for the pad filters |

## Verification
A corrupted byte index or bit counter shows up within one byte at the ports. SDA then carries the wrong byte of the frame, the control byte arrives early, or SDA stays pulled low during the master's acknowledge slot. A bad address decision shows in the very next ninth clock, as a missing or a spurious acknowledge. A stuck mode flag shows at `hs_mode_o` a few system clocks after the stop that should have cleared it. The bench compares every received bit of randomised frames against values it builds itself. It also checks the abort, wrap, not-acknowledge and master-code cases directly.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_SEND,
        ST_MACK,
        ST_HOLD
    } rb_state_e;

    localparam int FRAME_BYTES = 3;
    typedef logic [1:0] byte_idx_t;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int   WIDTH     = 2,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign stage_d[s] = async_i;
        end else begin : g_next
            assign stage_d[s] = stage_q[s-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= {WIDTH{RESET_VAL}};
            else         stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_rb_cond.sv
module i2c_rb_cond (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = scl_s_i;
        sda_d = sda_s_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_rise_o = !scl_q && scl_s_i;
    assign scl_fall_o = scl_q && !scl_s_i;
    assign start_o    = scl_q && scl_s_i && sda_q && !sda_s_i;
    assign stop_o     = scl_q && scl_s_i && !sda_q && sda_s_i;
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
    import i2c_rb_pkg::*;
#(
    parameter int               BYTE_W  = 8,
    parameter logic [BYTE_W-3:0] ADDR_HI = 6'b100110,
    parameter logic [4:0]       MCODE   = 5'b00001
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                scl_rise_i,
    input  logic                scl_fall_i,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                sda_s_i,
    input  logic                a0_i,
    input  logic [2*BYTE_W-1:0] data_i,
    input  logic                temp_i,
    output logic                pull_o,
    output logic                hs_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);
    localparam int DATA_W = 2 * BYTE_W;

    typedef struct packed {
        rb_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        byte_idx_t         idx;
        logic              rd;
        logic              mack;
        logic              oe;
        logic              hs;
        logic [DATA_W-1:0] data;
        logic              temp;
    } eng_t;

    eng_t q, d;

    function automatic logic [BYTE_W-1:0] pick_byte(byte_idx_t i, logic [DATA_W-1:0] w, logic t);
        case (i)
            2'd0:    return w[DATA_W-1:BYTE_W];
            2'd1:    return w[BYTE_W-1:0];
            default: return {{(BYTE_W-1){1'b0}}, t};
        endcase
    endfunction

    logic [BYTE_W-2:0] my_addr;
    byte_idx_t         idx_next;
    logic [BYTE_W-1:0] byte_next;

    assign my_addr   = {ADDR_HI, a0_i};
    assign idx_next  = (q.idx == byte_idx_t'(FRAME_BYTES - 1)) ? '0 : q.idx + 2'd1;
    assign byte_next = pick_byte(idx_next, q.data, q.temp);

    always_comb begin
        d = q;
        if (stop_i) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.hs  = 1'b0;
            d.cnt = '0;
        end else if (start_i) begin
            d.st  = ST_ADDR;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        d.rx  = {q.rx[BYTE_W-2:0], sda_s_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == BYTE_END) begin
                        d.cnt = '0;
                        if (q.rx[BYTE_W-1:1] == my_addr) begin
                            d.st   = ST_AACK;
                            d.oe   = 1'b1;
                            d.rd   = q.rx[0];
                            d.data = data_i;
                            d.temp = temp_i;
                        end else begin
                            d.st = ST_HOLD;
                            if (q.rx[BYTE_W-1 -: 5] == MCODE) d.hs = 1'b1;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        if (q.rd) begin
                            d.st  = ST_SEND;
                            d.idx = '0;
                            d.tx  = pick_byte('0, q.data, q.temp);
                            d.oe  = !q.data[DATA_W-1];
                        end else begin
                            d.st = ST_HOLD;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == BYTE_END) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_MACK;
                        end else begin
                            d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                            d.oe = !q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        d.mack = !sda_s_i;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            d.st  = ST_SEND;
                            d.idx = idx_next;
                            d.tx  = byte_next;
                            d.oe  = !byte_next[BYTE_W-1];
                        end else begin
                            d.st = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign pull_o = q.oe;
    assign hs_o   = q.hs;

    p_pull_on_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.oe != $past(q.oe)) |-> $past(scl_fall_i || start_i || stop_i));
    p_hold_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_HOLD || q.st == ST_IDLE) |-> !q.oe);
    p_stop_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!q.hs && !q.oe && q.st == ST_IDLE));
    p_start_aborts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (q.st == ST_ADDR && !q.oe));
    p_hs_no_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.hs) |-> (!q.oe && q.st == ST_HOLD));
endmodule

// File: rtl/i2c_readback_target.sv
module i2c_readback_target #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                strap_a0_i,
    input  logic [2*BYTE_W-1:0] conv_data_i,
    input  logic                src_temp_i,
    output logic                sda_pull_o,
    output logic                hs_mode_o
);
    logic [1:0] line_s;
    logic scl_rise, scl_fall, start_c, stop_c;

    i2c_rb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .async_i({scl_i, sda_i}), .sync_o(line_s)
    );

    i2c_rb_cond cond_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .scl_s_i(line_s[1]), .sda_s_i(line_s[0]),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_c), .stop_o(stop_c)
    );

    i2c_rb_engine #(.BYTE_W(BYTE_W)) engine_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_c), .stop_i(stop_c),
        .sda_s_i(line_s[0]), .a0_i(strap_a0_i),
        .data_i(conv_data_i), .temp_i(src_temp_i),
        .pull_o(sda_pull_o), .hs_o(hs_mode_o)
    );
endmodule

// File: tb/i2c_readback_target_tb_top.sv
`timescale 1ns/100ps
module i2c_readback_target_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, a0 = 1'b0, temp = 1'b0;
    logic [15:0] data = '0;
    logic pull, hs;
    logic sda_bus;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;
    assign sda_bus = pull ? 1'b0 : sda_m;

    i2c_readback_target dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_a0_i(a0), .conv_data_i(data), .src_temp_i(temp),
        .sda_pull_o(pull), .hs_mode_o(hs)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int i, logic [15:0] w, logic t);
        case (i % 3)
            0: return w[15:8];
            1: return w[7:0];
            default: return {7'b0, t};
        endcase
    endfunction

    task automatic hold(int n); repeat (n) @(negedge clk); endtask

    task automatic do_start;
        sda_m = 1'b1; hold(10); scl = 1'b1; hold(10);
        sda_m = 1'b0; hold(10); scl = 1'b0; hold(10);
    endtask

    task automatic do_stop;
        sda_m = 1'b0; hold(10); scl = 1'b1; hold(10);
        sda_m = 1'b1; hold(10);
    endtask

    task automatic do_bit(logic b, output logic r);
        sda_m = b; hold(10); scl = 1'b1; hold(5);
        r = sda_bus; hold(5); scl = 1'b0; hold(10);
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) do_bit(b[i], r);
        do_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(logic mack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            do_bit(1'b1, r);
            v[i] = r;
        end
        do_bit(!mack, r);
    endtask

    task automatic read_frame(string req, int n, logic [15:0] w, logic t);
        logic ack;
        logic [7:0] v;
        do_start;
        send_byte({6'b100110, a0, 1'b1}, ack);
        chk({req, " R2 ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            chk(req, v, exp_byte(i, w, t));
        end
        chk({req, " R6 released"}, pull, 0);
        do_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v, ad;
        void'($urandom(32'd4242));
        hold(4);
        chk("R1 pull", pull, 0);
        chk("R1 hs", hs, 0);
        rst_n = 1'b1; hold(10);
        chk("R1 pull after release", pull, 0);

        // R3/R4 directed frame, active register
        data = 16'hA53C; temp = 1'b0;
        read_frame("R3 frame", 3, 16'hA53C, 1'b0);
        // R4 temporary register, strap A0 = 1
        a0 = 1'b1; data = 16'h0F81; temp = 1'b1;
        read_frame("R4 ctrl", 3, 16'h0F81, 1'b1);
        // R5 wrap: five bytes
        read_frame("R5 wrap", 5, 16'h0F81, 1'b1);

        // R3 snapshot: change data after address match
        data = 16'h1234; temp = 1'b0;
        do_start;
        send_byte({6'b100110, a0, 1'b1}, ack);
        chk("R3 ack", ack, 1);
        data = 16'hFFFF; temp = 1'b1;
        recv_byte(1'b1, v); chk("R3 snapshot hi", v, 8'h12);
        recv_byte(1'b1, v); chk("R3 snapshot lo", v, 8'h34);
        recv_byte(1'b0, v); chk("R4 snapshot ctrl", v, 8'h00);
        do_stop;

        // R2 wrong strap: A0 mismatch
        do_start;
        send_byte({6'b100110, !a0, 1'b1}, ack);
        chk("R2 no ack", ack, 0);
        recv_byte(1'b1, v); chk("R2 released after miss", v, 8'hFF);
        do_stop;

        // R6 nack after high byte
        data = 16'h0000; temp = 1'b0;
        do_start;
        send_byte({6'b100110, a0, 1'b1}, ack);
        recv_byte(1'b0, v); chk("R6 hi", v, 8'h00);
        recv_byte(1'b1, v); chk("R6 released after nack", v, 8'hFF);
        do_stop;

        // R7 master code, repeated start keeps hs, R8 stop clears
        data = 16'h5AA5;
        do_start;
        send_byte(8'h0B, ack);
        chk("R7 no ack on code", ack, 0);
        chk("R7 hs set", hs, 1);
        do_start;
        chk("R7 hs kept over rstart", hs, 1);
        send_byte({6'b100110, a0, 1'b1}, ack);
        chk("R7 ack in hs", ack, 1);
        recv_byte(1'b0, v); chk("R7 hi in hs", v, 8'h5A);
        chk("R7 hs still set", hs, 1);
        do_stop; hold(5);
        chk("R8 hs cleared", hs, 0);
        chk("R8 released", pull, 0);

        // R9 abort during address and during send
        do_start;
        for (int i = 0; i < 4; i++) do_bit(1'b1, ack);
        do_start;
        send_byte({6'b100110, a0, 1'b1}, ack);
        chk("R9 ack after abort in addr", ack, 1);
        recv_byte(1'b0, v); chk("R9 hi", v, 8'h5A);
        do_stop;
        data = 16'hFF11;
        do_start;
        send_byte({6'b100110, a0, 1'b1}, ack);
        for (int i = 0; i < 3; i++) do_bit(1'b1, ack);
        do_start;
        chk("R9 released on rstart", pull, 0);
        send_byte({6'b100110, a0, 1'b1}, ack);
        chk("R9 ack after abort in send", ack, 1);
        recv_byte(1'b1, v); chk("R9 hi again", v, 8'hFF);
        recv_byte(1'b0, v); chk("R9 lo", v, 8'h11);
        do_stop;

        // R2 write access acked then released
        do_start;
        send_byte({6'b100110, a0, 1'b0}, ack);
        chk("R2 write ack", ack, 1);
        send_byte(8'h00, ack);
        chk("R2 write data no ack", ack, 0);
        do_stop;

        // random frames (R3 R4 R5 R2 R10)
        for (int k = 0; k < 24; k++) begin
            int n;
            logic [15:0] w;
            logic t, hit;
            w = 16'($urandom); t = 1'($urandom);
            a0 = 1'($urandom); hit = ($urandom % 4) != 0;
            n = 1 + int'($urandom % 5);
            data = w; temp = t;
            ad = hit ? {6'b100110, a0, 1'b1} : 8'($urandom);
            if (ad[7:1] == {6'b100110, a0} && !hit) ad[7] = 1'b0;
            if (ad[7:3] == 5'b00001) ad[6] = 1'b1;
            hit = (ad[7:1] == {6'b100110, a0});
            do_start;
            send_byte({ad[7:1], 1'b1}, ack);
            chk("R2 random ack", ack, hit);
            for (int i = 0; i < n; i++) begin
                recv_byte(i != n - 1, v);
                chk("R3 random byte", v, hit ? exp_byte(i, w, t) : 8'hFF);
            end
            do_stop;
            chk("R8 random hs", hs, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule